// File: doc/BRIEF.md
# Debug memory-access request decoder

The block sits behind a debug interconnect and rebuilds memory transfer requests from a stream of 16-bit payload words. Every word carries two request bytes, the earlier one in the upper half. The byte stream starts with two header bytes. The address follows, and for a write the data bytes come after it. Because the block sees only the flat word stream, a request may run across any number of packets.

Once the address is complete, the block checks that it is word-aligned and reports the request type to a response path. It then drives a word-wide memory port with a valid/ready handshake. Burst requests become a series of whole-word accesses at rising word addresses. Single requests become one access whose byte lanes are picked by a mask. Write bytes are collected into a full data word before that word is written. Address width `AW` and data width `DW` are parameters, each 16, 32 or 64.

Top module: `dmreq_parser`

## Requirements
- R1: Each input word gives two request bytes. Bits [15:8] are consumed before bits [7:0].
- R2: In request byte 0, bit 7 = write, bit 6 = burst (1) or single (0), and bit 5 = synchronous write. Bits [4:0] are ignored and change no output.
- R3: Request byte 1 is the size/select field. The next AW/8 bytes form the start address, most significant byte first, and the address appears unchanged on `mem_addr` for the first access.
- R4: In burst mode the size field gives the number of word accesses. Each access has all strobes set, and each address is the previous one plus DW/8.
- R5: In single mode exactly one access is made, and `mem_strb` equals bits [DW/8-1:0] of the size field.
- R6: Write data byte k of a request lands in word k/(DW/8), in lane k mod DW/8, meaning bits [8*(k mod DW/8)+7 : 8*(k mod DW/8)]. A write access is issued only after its word is complete.
- R7: After the last address byte of an aligned read or synchronous write, `rsp_valid` pulses for one cycle. It carries the write flag, the burst flag and the size field. An asynchronous write produces no pulse.
- R8: If the start address has a nonzero byte offset within a data word, `req_err` pulses for one cycle and no memory access or response follows. For a write, the data bytes the request declares are consumed and discarded.
- R9: A burst request with size 0 makes no memory access.
- R10: While `mem_valid` is high and `mem_ready` is low, the address, strobes and write data hold steady, and input is stalled rather than lost.
- R11: After the last data byte of a write, or the last address byte of a read, the next byte is taken as a new header. Back-to-back requests are decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Payload word offered |
| in_word | input | 16 | Payload word, earlier byte in [15:8] |
| in_ready | output | 1 | Payload word accepted this cycle when valid |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Byte address of the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_strb | output | DW/8 | Byte-lane enables |
| mem_wdata | output | DW | Write data, lane 0 in the low byte |
| rsp_valid | output | 1 | One-cycle pulse: a response is owed |
| rsp_write | output | 1 | Request was a write |
| rsp_burst | output | 1 | Request was a burst |
| rsp_size | output | 8 | Size/select field of the request |
| req_err | output | 1 | One-cycle pulse: misaligned start address |

## Verification
The hardest case to reach from the ports is a misaligned write whose discarded data runs across several input words and is followed at once by a valid request. The block must count the dropped bytes exactly, or the next header is read from the wrong byte. A similar risk comes from memory back-pressure in the middle of a burst while later payload words are already waiting. The stimulus reaches these cases with directed misaligned bursts placed directly before a read, and with a mode that holds `mem_ready` low for most cycles. Seeded random requests add mixed widths of burst, select mask, alignment and reserved-bit content.

// File: rtl/dmreq_pkg.sv
package dmreq_pkg;

  typedef enum logic [2:0] {
    ST_HDR0,
    ST_HDR1,
    ST_ADDR,
    ST_DATA,
    ST_ISSUE,
    ST_DROP
  } prs_state_e;

  typedef struct packed {
    logic wr;
    logic burst;
    logic sync;
  } req_kind_t;

  // upper three header bits: write, burst, sync
  function automatic req_kind_t decode_kind(input logic [2:0] top3);
    req_kind_t k;
    k.wr    = top3[2];
    k.burst = top3[1];
    k.sync  = top3[0];
    return k;
  endfunction

endpackage

// File: rtl/dmreq_byte_unpack.sv
module dmreq_byte_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_byte,
  input  logic        out_ready
);

  logic [15:0] held;
  logic        full;
  logic        second;

  logic out_fire;
  logic last_half;

  assign out_valid = full;
  assign out_byte  = second ? held[7:0] : held[15:8];
  assign out_fire  = full && out_ready;
  assign last_half = out_fire && second;
  assign in_ready  = !full || last_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      full   <= 1'b0;
      second <= 1'b0;
    end else if (in_valid && in_ready) begin
      held   <= in_word;
      full   <= 1'b1;
      second <= 1'b0;
    end else if (last_half) begin
      full   <= 1'b0;
      second <= 1'b0;
    end else if (out_fire) begin
      second <= 1'b1;
    end
  end

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    full && !out_ready |=> full && $stable(out_byte)); // R1

endmodule

// File: rtl/dmreq_word_pack.sv
module dmreq_word_pack #(
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [$clog2(DW/8)-1:0]    lane,
  input  logic [7:0]                 din,
  output logic [DW-1:0]              word
);

  localparam int DB = DW / 8;
  localparam int LW = $clog2(DB);

  for (genvar g = 0; g < DB; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word[8*g +: 8] <= '0;
      end else if (load && lane == LW'(g)) begin
        word[8*g +: 8] <= din;
      end
    end
  end

endmodule

// File: rtl/dmreq_parser.sv
module dmreq_parser
  import dmreq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_word,
  output logic              in_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [DW/8-1:0]   mem_strb,
  output logic [DW-1:0]     mem_wdata,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic              rsp_burst,
  output logic [7:0]        rsp_size,
  output logic              req_err
);

  localparam int AB    = AW / 8;
  localparam int DB    = DW / 8;
  localparam int LW    = $clog2(DB);
  localparam int ACW   = $clog2(AB);
  localparam int DROPW = 9 + LW;

  // ---------------- arithmetic helpers ----------------
  function automatic logic is_aligned(input logic [LW-1:0] low);
    return low == '0;
  endfunction

  function automatic logic [8:0] word_count(input logic burst, input logic [7:0] sel);
    return burst ? {1'b0, sel} : 9'd1;
  endfunction

  function automatic logic [DB-1:0] lane_mask(input logic burst, input logic [DB-1:0] sel_lo);
    return burst ? {DB{1'b1}} : sel_lo;
  endfunction

  function automatic logic [DROPW-1:0] drop_bytes(input logic [8:0] words);
    return DROPW'(words) << LW;
  endfunction

  // ---------------- state ----------------
  prs_state_e       state;
  req_kind_t        kind;
  logic [7:0]       sel;
  logic [AW-9:0]    addr_sh;
  logic [ACW-1:0]   acnt;
  logic [LW-1:0]    lane_cnt;
  logic [8:0]       words_left;
  logic [DROPW-1:0] drop_left;
  logic [AW-1:0]    mem_addr_r;

  // ---------------- byte stream ----------------
  logic       b_valid;
  logic [7:0] b_byte;
  logic       b_ready;

  dmreq_byte_unpack u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .out_valid (b_valid),
    .out_byte  (b_byte),
    .out_ready (b_ready)
  );

  // ---------------- named internal events ----------------
  logic          byte_fire;
  logic [AW-1:0] addr_full;
  logic          addr_done;
  logic [8:0]    new_words;
  logic          addr_ok;
  logic          word_full;
  logic          mem_fire;
  logic          last_word;
  logic          data_load;

  assign b_ready   = (state == ST_HDR0) || (state == ST_HDR1) || (state == ST_ADDR) ||
                     (state == ST_DATA) || (state == ST_DROP);
  assign byte_fire = b_valid && b_ready;
  assign addr_full = {addr_sh, b_byte};
  assign addr_done = byte_fire && (state == ST_ADDR) && (acnt == ACW'(AB - 1));
  assign new_words = word_count(kind.burst, sel);
  assign addr_ok   = is_aligned(addr_full[LW-1:0]);
  assign data_load = byte_fire && (state == ST_DATA);
  assign word_full = data_load && (lane_cnt == LW'(DB - 1));
  assign mem_fire  = mem_valid && mem_ready;
  assign last_word = (words_left == 9'd1);

  // ---------------- write word gathering ----------------
  dmreq_word_pack #(.DW(DW)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (data_load),
    .lane  (lane_cnt),
    .din   (b_byte),
    .word  (mem_wdata)
  );

  // ---------------- parser ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HDR0;
      kind       <= '0;
      sel        <= '0;
      addr_sh    <= '0;
      acnt       <= '0;
      lane_cnt   <= '0;
      words_left <= '0;
      drop_left  <= '0;
      mem_addr_r <= '0;
      rsp_valid  <= 1'b0;
      rsp_write  <= 1'b0;
      rsp_burst  <= 1'b0;
      rsp_size   <= '0;
      req_err    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      req_err   <= 1'b0;
      unique case (state)
        ST_HDR0: begin
          if (byte_fire) begin
            kind  <= decode_kind(b_byte[7:5]);
            state <= ST_HDR1;
          end
        end
        ST_HDR1: begin
          if (byte_fire) begin
            sel   <= b_byte;
            acnt  <= '0;
            state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (byte_fire) begin
            addr_sh <= addr_full[AW-9:0];
            acnt    <= acnt + ACW'(1);
          end
          if (addr_done) begin
            mem_addr_r <= addr_full;
            words_left <= new_words;
            lane_cnt   <= '0;
            if (!addr_ok) begin
              req_err <= 1'b1;
              if (kind.wr && new_words != 9'd0) begin
                drop_left <= drop_bytes(new_words);
                state     <= ST_DROP;
              end else begin
                state <= ST_HDR0;
              end
            end else begin
              rsp_valid <= !kind.wr || kind.sync;
              rsp_write <= kind.wr;
              rsp_burst <= kind.burst;
              rsp_size  <= sel;
              if (new_words == 9'd0) state <= ST_HDR0;
              else if (kind.wr)      state <= ST_DATA;
              else                   state <= ST_ISSUE;
            end
          end
        end
        ST_DATA: begin
          if (byte_fire) begin
            lane_cnt <= lane_cnt + LW'(1);
          end
          if (word_full) state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (mem_fire) begin
            mem_addr_r <= mem_addr_r + AW'(DB);
            words_left <= words_left - 9'd1;
            if (last_word)    state <= ST_HDR0;
            else if (kind.wr) state <= ST_DATA;
            else              state <= ST_ISSUE;
          end
        end
        ST_DROP: begin
          if (byte_fire) begin
            drop_left <= drop_left - DROPW'(1);
            if (drop_left == DROPW'(1)) state <= ST_HDR0;
          end
        end
        default: state <= ST_HDR0;
      endcase
    end
  end

  assign mem_valid = (state == ST_ISSUE);
  assign mem_we    = kind.wr;
  assign mem_addr  = mem_addr_r;
  assign mem_strb  = lane_mask(kind.burst, sel[DB-1:0]);

  // ---------------- assertions ----------------
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_strb) && $stable(mem_wdata)); // R10

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !mem_valid && !rsp_valid); // R8

  AST_ALIGNED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[LW-1:0] == '0); // R8

  AST_WRITE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) && mem_we |-> $past(word_full)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire && !last_word |=> mem_addr == $past(mem_addr) + AW'(DB)); // R4

  AST_ASYNC_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_write || kind.sync); // R7

endmodule

// File: tb/dmreq_parser_bench.sv
module dmreq_parser_bench;

  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int AB  = AW / 8;
  localparam int DB  = DW / 8;
  localparam int OPW = AW + 1 + DB + DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [15:0]   in_word = '0;
  logic          in_ready;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DB-1:0] mem_strb;
  logic [DW-1:0] mem_wdata;
  logic          rsp_valid;
  logic          rsp_write;
  logic          rsp_burst;
  logic [7:0]    rsp_size;
  logic          req_err;

  always #2 clk = ~clk;

  dmreq_parser #(.AW(AW), .DW(DW)) u_dmreq_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_strb(mem_strb),
    .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_write(rsp_write),
    .rsp_burst(rsp_burst), .rsp_size(rsp_size), .req_err(req_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [OPW-1:0] exp_ops[$];
  logic [OPW-1:0] got_ops[$];
  logic [9:0]     exp_rsp[$];
  logic [9:0]     got_rsp[$];
  int exp_err = 0;
  int got_err = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory side: pick ready away from the edge, then record handshakes and pulses
  always @(negedge clk) begin
    if (stall_mode) mem_ready = ($urandom() % 5) == 0;
    else            mem_ready = ($urandom() % 4) != 0;
    #1;
    if (rst_n) begin
      if (mem_valid && mem_ready)
        got_ops.push_back({mem_addr, mem_we, mem_strb, mem_we ? mem_wdata : {DW{1'b0}}});
      if (rsp_valid) got_rsp.push_back({rsp_write, rsp_burst, rsp_size});
      if (req_err) got_err++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  // builds the request, the expected accesses and pulses, sends it and compares
  task automatic run_req(input bit wr, input bit burst, input bit sync, input logic [4:0] resv,
                         input logic [7:0] sel, input logic [AW-1:0] addr, input string tag);
    logic [7:0] bq[$];
    logic [7:0] dq[$];
    int words;
    bit aligned;
    int waitc;
    words   = burst ? int'(sel) : 1;
    aligned = (addr % DB) == 0;
    bq.push_back({wr, burst, sync, resv});
    bq.push_back(sel);
    for (int i = AB - 1; i >= 0; i--) bq.push_back(addr[8*i +: 8]);
    if (wr) begin
      for (int i = 0; i < words * DB; i++) begin
        dq.push_back(8'($urandom()));
        bq.push_back(dq[i]);
      end
    end
    if (!aligned) begin
      exp_err = 1;
    end else begin
      if (!wr || sync) exp_rsp.push_back({wr, burst, sel});
      for (int w = 0; w < words; w++) begin
        logic [DW-1:0] dw;
        logic [DB-1:0] st;
        dw = '0;
        if (wr) for (int k = 0; k < DB; k++) dw = dw | (DW'(dq[w*DB + k]) << (8*k));
        st = burst ? {DB{1'b1}} : sel[DB-1:0];
        exp_ops.push_back({addr + AW'(w*DB), wr, st, dw});
      end
    end
    for (int i = 0; i < bq.size(); i += 2) send_word({bq[i], bq[i+1]});
    @(negedge clk);
    in_valid = 1'b0;
    waitc = 0;
    while ((got_ops.size() < exp_ops.size() || got_rsp.size() < exp_rsp.size() ||
            got_err < exp_err) && waitc < 4000) begin
      @(negedge clk);
      waitc++;
    end
    repeat (8) @(negedge clk);
    chk(got_ops.size() == exp_ops.size(), {tag, " access count"}, 128'(got_ops.size()), 128'(exp_ops.size()));
    for (int i = 0; i < exp_ops.size() && i < got_ops.size(); i++)
      chk(got_ops[i] == exp_ops[i], {tag, " access addr/we/strb/data"}, 128'(got_ops[i]), 128'(exp_ops[i]));
    chk(got_rsp.size() == exp_rsp.size(), {tag, " R7 response count"}, 128'(got_rsp.size()), 128'(exp_rsp.size()));
    for (int i = 0; i < exp_rsp.size() && i < got_rsp.size(); i++)
      chk(got_rsp[i] == exp_rsp[i], {tag, " R7 response fields"}, 128'(got_rsp[i]), 128'(exp_rsp[i]));
    chk(got_err == exp_err, {tag, " R8 error pulse"}, 128'(got_err), 128'(exp_err));
    exp_ops.delete(); got_ops.delete(); exp_rsp.delete(); got_rsp.delete();
    exp_err = 0; got_err = 0;
  endtask

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    chk(mem_valid == 1'b0, "reset mem_valid R10", 128'(mem_valid), 128'(0));
    chk(rsp_valid == 1'b0 && req_err == 1'b0, "reset pulses R7", 128'({rsp_valid, req_err}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "reset in_ready R1", 128'(in_ready), 128'(1));

    // R5 single read with lane mask; R3 address order
    run_req(1'b0, 1'b0, 1'b0, 5'd0, 8'b0000_0101, 32'h1234_5678, "R5 R3 single read");
    // R4 R6 sync burst write of three words; R1 byte order in data
    run_req(1'b1, 1'b1, 1'b1, 5'd0, 8'd3, 32'h0000_1000, "R4 R6 R1 burst write");
    // R2 reserved bits set, async single write: no response
    run_req(1'b1, 1'b0, 1'b0, 5'h1F, 8'hFF, 32'hCAFE_0010, "R2 async write");
    // R8 misaligned burst write, data dropped; R11 next request decodes
    run_req(1'b1, 1'b1, 1'b1, 5'd0, 8'd2, 32'h0000_2001, "R8 misaligned write");
    run_req(1'b0, 1'b1, 1'b0, 5'h0A, 8'd2, 32'h0000_3000, "R11 read after drop");
    run_req(1'b0, 1'b0, 1'b0, 5'd0, 8'h0F, 32'h0000_4003, "R8 misaligned read");
    // R9 burst of size zero
    run_req(1'b0, 1'b1, 1'b0, 5'd0, 8'd0, 32'h0000_5000, "R9 zero burst read");
    run_req(1'b1, 1'b1, 1'b1, 5'd0, 8'd0, 32'h0000_5100, "R9 zero burst write");
    // R10 heavy memory back-pressure
    stall_mode = 1'b1;
    run_req(1'b0, 1'b1, 1'b0, 5'd0, 8'd4, 32'h0000_6000, "R10 stalled read");
    run_req(1'b1, 1'b1, 1'b1, 5'd0, 8'd5, 32'h0000_7000, "R10 stalled write");
    stall_mode = 1'b0;

    // random mix
    for (int n = 0; n < 60; n++) begin
      bit wr, burst, sync;
      logic [7:0] sel;
      logic [AW-1:0] a;
      wr    = 1'($urandom());
      burst = 1'($urandom());
      sync  = 1'($urandom());
      sel   = burst ? 8'($urandom() % 7) : 8'($urandom());
      a     = AW'($urandom());
      if (($urandom() % 6) != 0) a = a & ~AW'(DB - 1);
      stall_mode = ($urandom() % 4) == 0;
      run_req(wr, burst, sync, 5'($urandom()), sel, a, "R11 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule